// File: doc/BRIEF.md
# Accumulator ALU and Instruction Decoder

This block is the execute stage of a small 8-bit accumulator processor with 14-bit instruction words. It takes the fetched instruction word, the working register W, the value already read from the addressed register, and the current carry flag. In the same cycle it decodes the word and produces the result byte. It also says where the result goes (W or the register) and whether it is written at all. It reports which of the carry, half-carry and zero flags change and to what values, and whether the following instruction should be skipped.

The block has no state and no clock. The surrounding core owns the register file, the status register, program-counter sequencing and the skip mechanism. This block only computes. A single shared adder serves add, subtract, increment and decrement. Logic, rotate, nibble-swap and single-bit operations sit in a separate unit. Control, branch and call encodings are not decoded here and leave the block quiet.

Top module: `acc_alu`

## Requirements
- R1: For a register-operand instruction, bit 7 of the word picks the destination (`dest_reg` = 0 selects W, 1 selects the register), and `wr_en` is asserted.
- R2: Opcode 011011 (bits 13:8) adds W and R. The result is the low 8 bits. C is the carry out of bit 7, HC is the carry out of bit 3, and Z shows a zero result. All three flags are updated.
- R3: Opcode 011100 computes R minus W as R + ~W + 1. C is 1 when no borrow occurs (R >= W). HC is the carry out of the low-nibble sum R[3:0] + ~W[3:0] + 1. Z shows a zero result. All three flags are updated.
- R4: Opcodes 010010 (AND), 010011 (OR), 010100 (XOR), 011111 (complement R) and 011000 (copy R) produce their result and update only Z.
- R5: Opcodes 011001 (R+1) and 011101 (R-1) wrap modulo 256 and update only Z.
- R6: Opcodes 011010 (R+1) and 011110 (R-1) write their result. They request a skip when that result is zero and change no flag.
- R7: Opcode 010101 rotates left through carry (C into bit 0, bit 7 into C). Opcode 010110 rotates right through carry (C into bit 7, bit 0 into C). Both update only C.
- R8: Opcode 010111 swaps the two nibbles of R and changes no flag.
- R9: A word with bits 13:12 = 00 is a single-bit operation on bit b = bits 9:7, and bits 11:10 select the kind. 00 clears bit b and 10 sets bit b; both write the register and change no flag. 01 skips when R(b) = 0 and 11 skips when R(b) = 1; neither writes.
- R10: The immediate forms 111010 (load), 110100 (AND), 110101 (OR) and 110110 (XOR) use bits 7:0 as the operand and always write W. Load changes no flag; the other three update only Z.
- R11: Opcode 010000 with bit 7 = 1 clears W, and opcode 010001 with bit 7 = 0 clears the register; both set Z. Opcode 010001 with bit 7 = 1 stores W into the register and changes no flag.
- R12: Every other encoding produces no write, no flag update and no skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 14 | Instruction word being executed |
| w_in | input | 8 | Working register value |
| r_in | input | 8 | Value of the addressed register |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Computed byte, valid when `wr_en` is high |
| dest_reg | output | 1 | 0: write W, 1: write the register |
| wr_en | output | 1 | Result is to be written |
| c_out | output | 1 | New carry, valid when `c_upd` is high |
| hc_out | output | 1 | New half carry, valid when `hc_upd` is high |
| z_out | output | 1 | New zero flag, valid when `z_upd` is high |
| c_upd | output | 1 | Carry flag is to be updated |
| hc_upd | output | 1 | Half-carry flag is to be updated |
| z_upd | output | 1 | Zero flag is to be updated |
| skip | output | 1 | Skip the next instruction |

## Verification
The bench uses the package defaults: an 8-bit datapath, a 14-bit word and a 3-bit bit index. At these sizes every one of the 16384 instruction encodings can be driven, each with random operands and carry. This covers each undecoded hole and every destination-bit and bit-index combination. Directed cases then steer the adder to its edges: a sum that wraps to zero, a subtract of equal operands, a subtract from zero, an increment past 255 and a decrement that reaches zero. These show carry, half carry, borrow and the skip-on-zero behaviour at the exact points where they switch.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  parameter int DATA_W = 8;
  parameter int INSN_W = 14;
  parameter int OPC_W  = 6;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int DEST_POS = OPC_LSB - 1;
  localparam int BSEL_LSB = DEST_POS;

  localparam logic [OPC_W-1:0] OPC_ADD   = 6'b011011;
  localparam logic [OPC_W-1:0] OPC_SUB   = 6'b011100;
  localparam logic [OPC_W-1:0] OPC_AND   = 6'b010010;
  localparam logic [OPC_W-1:0] OPC_IOR   = 6'b010011;
  localparam logic [OPC_W-1:0] OPC_XOR   = 6'b010100;
  localparam logic [OPC_W-1:0] OPC_COM   = 6'b011111;
  localparam logic [OPC_W-1:0] OPC_INC   = 6'b011001;
  localparam logic [OPC_W-1:0] OPC_DEC   = 6'b011101;
  localparam logic [OPC_W-1:0] OPC_INCSZ = 6'b011010;
  localparam logic [OPC_W-1:0] OPC_DECSZ = 6'b011110;
  localparam logic [OPC_W-1:0] OPC_RL    = 6'b010101;
  localparam logic [OPC_W-1:0] OPC_RR    = 6'b010110;
  localparam logic [OPC_W-1:0] OPC_SWAP  = 6'b010111;
  localparam logic [OPC_W-1:0] OPC_MOV   = 6'b011000;
  localparam logic [OPC_W-1:0] OPC_MISC  = 6'b010000;
  localparam logic [OPC_W-1:0] OPC_STCL  = 6'b010001;
  localparam logic [OPC_W-1:0] OPC_LDI   = 6'b111010;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b110100;
  localparam logic [OPC_W-1:0] OPC_IORI  = 6'b110101;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'b110110;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM,
    OP_INC, OP_DEC, OP_INCSZ, OP_DECSZ, OP_RL, OP_RR, OP_SWAP,
    OP_MOV, OP_CLR, OP_STW, OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS,
    OP_LDI, OP_ANDI, OP_IORI, OP_XORI
  } alu_op_e;

  typedef struct packed {
    alu_op_e           op;
    logic              dest_reg;
    logic [BIT_W-1:0]  bit_sel;
    logic [DATA_W-1:0] imm;
  } dec_s;

  function automatic logic [DATA_W:0] wide_add(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic              cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  function automatic logic nibble_carry(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic              cin);
    logic [HALF_W:0] part;
    part = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    return part[HALF_W];
  endfunction

  function automatic logic [DATA_W-1:0] swap_halves(input logic [DATA_W-1:0] v);
    return {v[HALF_W-1:0], v[DATA_W-1:HALF_W]};
  endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_s              dec
);

  logic [OPC_W-1:0] opc;
  logic             bitop_grp;
  logic             dbit;

  assign opc       = instr[INSN_W-1:OPC_LSB];
  assign bitop_grp = (instr[INSN_W-1:INSN_W-2] == 2'b00);
  assign dbit      = instr[DEST_POS];

  always_comb begin
    dec.op       = OP_NONE;
    dec.dest_reg = dbit;
    dec.bit_sel  = instr[BSEL_LSB +: BIT_W];
    dec.imm      = instr[DATA_W-1:0];
    if (bitop_grp) begin
      dec.dest_reg = 1'b1;
      case (instr[INSN_W-3:INSN_W-4])
        2'b00:   dec.op = OP_BCLR;
        2'b01:   dec.op = OP_BTSC;
        2'b10:   dec.op = OP_BSET;
        default: dec.op = OP_BTSS;
      endcase
    end else begin
      case (opc)
        OPC_ADD:   dec.op = OP_ADD;
        OPC_SUB:   dec.op = OP_SUB;
        OPC_AND:   dec.op = OP_AND;
        OPC_IOR:   dec.op = OP_IOR;
        OPC_XOR:   dec.op = OP_XOR;
        OPC_COM:   dec.op = OP_COM;
        OPC_INC:   dec.op = OP_INC;
        OPC_DEC:   dec.op = OP_DEC;
        OPC_INCSZ: dec.op = OP_INCSZ;
        OPC_DECSZ: dec.op = OP_DECSZ;
        OPC_RL:    dec.op = OP_RL;
        OPC_RR:    dec.op = OP_RR;
        OPC_SWAP:  dec.op = OP_SWAP;
        OPC_MOV:   dec.op = OP_MOV;
        OPC_MISC: begin
          if (dbit) begin
            dec.op       = OP_CLR;
            dec.dest_reg = 1'b0;
          end
        end
        OPC_STCL: begin
          dec.op       = dbit ? OP_STW : OP_CLR;
          dec.dest_reg = 1'b1;
        end
        OPC_LDI:  begin dec.op = OP_LDI;  dec.dest_reg = 1'b0; end
        OPC_ANDI: begin dec.op = OP_ANDI; dec.dest_reg = 1'b0; end
        OPC_IORI: begin dec.op = OP_IORI; dec.dest_reg = 1'b0; end
        OPC_XORI: begin dec.op = OP_XORI; dec.dest_reg = 1'b0; end
        default:  dec.op = OP_NONE;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown(instr)) begin
      AST_BITGRP_DECODE: assert (!bitop_grp ||
        dec.op inside {OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS}) // R9
        else $error("bit-group word decoded to a non-bit operation");
    end
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] r_in,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              half
);

  logic [DATA_W-1:0] opa, opb;
  logic              cin;
  logic [DATA_W:0]   full;

  always_comb begin
    opa = r_in;
    opb = '0;
    cin = 1'b0;
    case (op)
      OP_ADD:            begin opa = w_in; opb = r_in; end
      OP_SUB:            begin opb = ~w_in; cin = 1'b1; end
      OP_INC, OP_INCSZ:  cin = 1'b1;
      OP_DEC, OP_DECSZ:  opb = '1;
      default:           ;
    endcase
  end

  assign full  = wide_add(opa, opb, cin);
  assign sum   = full[DATA_W-1:0];
  assign carry = full[DATA_W];
  assign half  = nibble_carry(opa, opb, cin);

  always_comb begin
    if (!$isunknown({op, w_in, r_in})) begin
      AST_ADD_CARRY: assert (op != OP_ADD ||
        carry == ((32'(w_in) + 32'(r_in)) > ((32'd1 << DATA_W) - 1))) // R2
        else $error("add carry disagrees with operand magnitude");
      AST_SUB_NO_BORROW: assert (op != OP_SUB || carry == (r_in >= w_in)) // R3
        else $error("subtract carry disagrees with R >= W");
    end
  end

endmodule

// File: rtl/acc_alu_bitlogic.sv
module acc_alu_bitlogic
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] r_in,
  input  logic [DATA_W-1:0] imm,
  input  logic              c_in,
  input  logic [BIT_W-1:0]  bit_sel,
  output logic [DATA_W-1:0] res,
  output logic              rot_c,
  output logic              bit_val
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] src;
  logic              use_imm;

  assign use_imm = op inside {OP_LDI, OP_ANDI, OP_IORI, OP_XORI};
  assign src     = use_imm ? imm : r_in;
  assign mask    = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel;
  assign bit_val = r_in[bit_sel];

  always_comb begin
    res   = src;
    rot_c = c_in;
    case (op)
      OP_AND, OP_ANDI: res = w_in & src;
      OP_IOR, OP_IORI: res = w_in | src;
      OP_XOR, OP_XORI: res = w_in ^ src;
      OP_COM:          res = ~src;
      OP_SWAP:         res = swap_halves(src);
      OP_RL:           {rot_c, res} = {src, c_in};
      OP_RR:           {res, rot_c} = {c_in, src};
      OP_BCLR:         res = src & ~mask;
      OP_BSET:         res = src | mask;
      default:         res = src;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, r_in, bit_sel})) begin
      AST_BITOP_SINGLE: assert (!(op inside {OP_BCLR, OP_BSET}) ||
        $countones(res ^ r_in) <= 1) // R9
        else $error("bit operation altered more than one bit");
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [13:0] instr,
  input  logic [7:0]  w_in,
  input  logic [7:0]  r_in,
  input  logic        c_in,
  output logic [7:0]  result,
  output logic        dest_reg,
  output logic        wr_en,
  output logic        c_out,
  output logic        hc_out,
  output logic        z_out,
  output logic        c_upd,
  output logic        hc_upd,
  output logic        z_upd,
  output logic        skip
);

  dec_s              dec;
  logic [DATA_W-1:0] ar_sum, lg_res;
  logic              ar_carry, ar_half, lg_rot_c, lg_bit;
  logic              ar_zero;

  acc_alu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  acc_alu_arith u_arith (
    .op    (dec.op),
    .w_in  (w_in),
    .r_in  (r_in),
    .sum   (ar_sum),
    .carry (ar_carry),
    .half  (ar_half)
  );

  acc_alu_bitlogic u_logic (
    .op      (dec.op),
    .w_in    (w_in),
    .r_in    (r_in),
    .imm     (dec.imm),
    .c_in    (c_in),
    .bit_sel (dec.bit_sel),
    .res     (lg_res),
    .rot_c   (lg_rot_c),
    .bit_val (lg_bit)
  );

  assign ar_zero  = (ar_sum == '0);
  assign dest_reg = dec.dest_reg;
  assign z_out    = (result == '0);
  assign hc_out   = ar_half;

  always_comb begin
    result = lg_res;
    wr_en  = 1'b1;
    c_out  = c_in;
    c_upd  = 1'b0;
    hc_upd = 1'b0;
    z_upd  = 1'b0;
    skip   = 1'b0;
    case (dec.op)
      OP_ADD, OP_SUB: begin
        result = ar_sum;
        c_out  = ar_carry;
        c_upd  = 1'b1;
        hc_upd = 1'b1;
        z_upd  = 1'b1;
      end
      OP_INC, OP_DEC: begin
        result = ar_sum;
        z_upd  = 1'b1;
      end
      OP_INCSZ, OP_DECSZ: begin
        result = ar_sum;
        skip   = ar_zero;
      end
      OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV,
      OP_ANDI, OP_IORI, OP_XORI: z_upd = 1'b1;
      OP_RL, OP_RR: begin
        c_out = lg_rot_c;
        c_upd = 1'b1;
      end
      OP_SWAP, OP_BCLR, OP_BSET, OP_LDI: ;
      OP_CLR: begin
        result = '0;
        z_upd  = 1'b1;
      end
      OP_STW: result = w_in;
      OP_BTSC: begin
        wr_en = 1'b0;
        skip  = ~lg_bit;
      end
      OP_BTSS: begin
        wr_en = 1'b0;
        skip  = lg_bit;
      end
      default: wr_en = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({instr, w_in, r_in, c_in})) begin
      AST_UNDECODED_QUIET: assert (dec.op != OP_NONE ||
        !(wr_en || skip || c_upd || hc_upd || z_upd)) // R12
        else $error("undecoded word caused an effect");
      AST_IMM_TARGETS_W: assert (!(dec.op inside {OP_LDI, OP_ANDI, OP_IORI, OP_XORI}) ||
        (wr_en && !dest_reg)) // R10
        else $error("immediate operation not writing W");
      AST_SKIP_FLAGLESS: assert (!skip || !(c_upd || hc_upd || z_upd)) // R6
        else $error("skip request together with a flag update");
      AST_ROTATE_C_ONLY: assert (!(dec.op inside {OP_RL, OP_RR}) ||
        (c_upd && !hc_upd && !z_upd)) // R7
        else $error("rotate touched a flag other than carry");
      AST_BITTEST_NO_WRITE: assert (!(dec.op inside {OP_BTSC, OP_BTSS}) || !wr_en) // R9
        else $error("bit test requested a write");
    end
  end

endmodule

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [13:0] instr = '0;
  logic [7:0]  w_in = '0, r_in = '0;
  logic        c_in = 1'b0;
  logic [7:0]  result;
  logic        dest_reg, wr_en, c_out, hc_out, z_out, c_upd, hc_upd, z_upd, skip;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  acc_alu dut_i (
    .instr(instr), .w_in(w_in), .r_in(r_in), .c_in(c_in),
    .result(result), .dest_reg(dest_reg), .wr_en(wr_en),
    .c_out(c_out), .hc_out(hc_out), .z_out(z_out),
    .c_upd(c_upd), .hc_upd(hc_upd), .z_upd(z_upd), .skip(skip)
  );

  task automatic model(input logic [13:0] i, input logic [7:0] w, input logic [7:0] r,
                       input logic c, output logic e_wr, output logic e_dst,
                       output logic [7:0] e_res, output logic e_cu, output logic e_hu,
                       output logic e_zu, output logic e_c, output logic e_hc,
                       output logic e_z, output logic e_sk, output string tag);
    int wi, ri, res, b;
    wi = int'(w); ri = int'(r); res = 0;
    e_wr = 0; e_dst = i[7]; e_cu = 0; e_hu = 0; e_zu = 0;
    e_c = c; e_hc = 0; e_sk = 0; tag = "R12";
    if (i[13:12] == 2'b00) begin
      b = int'(i[9:7]); tag = "R9";
      case (i[11:10])
        2'b00: begin e_wr = 1; e_dst = 1; res = ri & ~(1 << b); end
        2'b10: begin e_wr = 1; e_dst = 1; res = ri | (1 << b); end
        2'b01: e_sk = ((ri >> b) & 1) == 0;
        default: e_sk = ((ri >> b) & 1) == 1;
      endcase
    end else begin
      case (i[13:8])
        6'b011011: begin tag = "R2"; e_wr = 1; res = wi + ri; e_c = res > 255;
          e_hc = ((wi % 16) + (ri % 16)) > 15; e_cu = 1; e_hu = 1; e_zu = 1; end
        6'b011100: begin tag = "R3"; e_wr = 1; res = ri - wi; e_c = ri >= wi;
          e_hc = (ri % 16) >= (wi % 16); e_cu = 1; e_hu = 1; e_zu = 1; end
        6'b010010: begin tag = "R4"; e_wr = 1; res = ri & wi; e_zu = 1; end
        6'b010011: begin tag = "R4"; e_wr = 1; res = ri | wi; e_zu = 1; end
        6'b010100: begin tag = "R4"; e_wr = 1; res = ri ^ wi; e_zu = 1; end
        6'b011111: begin tag = "R4"; e_wr = 1; res = 255 - ri; e_zu = 1; end
        6'b011000: begin tag = "R4"; e_wr = 1; res = ri; e_zu = 1; end
        6'b011001: begin tag = "R5"; e_wr = 1; res = ri + 1; e_zu = 1; end
        6'b011101: begin tag = "R5"; e_wr = 1; res = ri + 255; e_zu = 1; end
        6'b011010: begin tag = "R6"; e_wr = 1; res = (ri + 1) % 256; e_sk = res == 0; end
        6'b011110: begin tag = "R6"; e_wr = 1; res = (ri + 255) % 256; e_sk = res == 0; end
        6'b010101: begin tag = "R7"; e_wr = 1; res = ri * 2 + int'(c); e_c = r[7]; e_cu = 1; end
        6'b010110: begin tag = "R7"; e_wr = 1; res = ri / 2 + 128 * int'(c); e_c = r[0]; e_cu = 1; end
        6'b010111: begin tag = "R8"; e_wr = 1; res = (ri % 16) * 16 + ri / 16; end
        6'b010000: if (i[7]) begin tag = "R11"; e_wr = 1; e_dst = 0; res = 0; e_zu = 1; end
        6'b010001: begin tag = "R11"; e_wr = 1; e_dst = 1;
          if (i[7]) res = wi; else begin res = 0; e_zu = 1; end end
        6'b111010: begin tag = "R10"; e_wr = 1; e_dst = 0; res = int'(i[7:0]); end
        6'b110100: begin tag = "R10"; e_wr = 1; e_dst = 0; res = int'(i[7:0]) & wi; e_zu = 1; end
        6'b110101: begin tag = "R10"; e_wr = 1; e_dst = 0; res = int'(i[7:0]) | wi; e_zu = 1; end
        6'b110110: begin tag = "R10"; e_wr = 1; e_dst = 0; res = int'(i[7:0]) ^ wi; e_zu = 1; end
        default: ;
      endcase
    end
    e_res = res[7:0];
    e_z = (e_res == 8'd0);
  endtask

  task automatic run_one(input logic [13:0] i, input logic [7:0] w, input logic [7:0] r,
                         input logic c);
    logic e_wr, e_dst, e_cu, e_hu, e_zu, e_c, e_hc, e_z, e_sk;
    logic [7:0] e_res;
    string tag;
    bit bad;
    @(negedge clk);
    instr = i; w_in = w; r_in = r; c_in = c;
    model(i, w, r, c, e_wr, e_dst, e_res, e_cu, e_hu, e_zu, e_c, e_hc, e_z, e_sk, tag);
    @(posedge clk); #1;
    n_run++;
    bad = (wr_en !== e_wr) || (skip !== e_sk) || (c_upd !== e_cu) ||
          (hc_upd !== e_hu) || (z_upd !== e_zu) ||
          (e_wr && ((dest_reg !== e_dst) || (result !== e_res))) ||
          (e_cu && (c_out !== e_c)) || (e_hu && (hc_out !== e_hc)) ||
          (e_zu && (z_out !== e_z));
    if (bad) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s instr=%b W=%h R=%h C=%b | got wr=%b d=%b res=%h cu=%b hu=%b zu=%b c=%b hc=%b z=%b sk=%b | exp wr=%b d=%b res=%h cu=%b hu=%b zu=%b c=%b hc=%b z=%b sk=%b",
          tag, i, w, r, c, wr_en, dest_reg, result, c_upd, hc_upd, z_upd, c_out, hc_out, z_out, skip,
          e_wr, e_dst, e_res, e_cu, e_hu, e_zu, e_c, e_hc, e_z, e_sk);
    end
  endtask

  localparam int N_OPC = 20;
  logic [5:0] opc_list [N_OPC] = '{6'b011011, 6'b011100, 6'b010010, 6'b010011, 6'b010100,
    6'b011111, 6'b011001, 6'b011101, 6'b011010, 6'b011110, 6'b010101, 6'b010110,
    6'b010111, 6'b011000, 6'b010000, 6'b010001, 6'b111010, 6'b110100, 6'b110101, 6'b110110};

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial quiet state with an undecoded word: R12
    run_one(14'b010000_00000100, 8'h55, 8'hAA, 1'b1);
    // R2 corners: wrap to zero, half carry
    run_one(14'b011011_1_0000101, 8'hFF, 8'h01, 1'b0);
    run_one(14'b011011_0_0000101, 8'h08, 8'h08, 1'b0);
    // R3 corners: equal operands, subtract from zero
    run_one(14'b011100_0_0000011, 8'h3C, 8'h3C, 1'b0);
    run_one(14'b011100_1_0000011, 8'h01, 8'h00, 1'b1);
    // R5 wrap, R6 skip on zero
    run_one(14'b011001_1_0010000, 8'h00, 8'hFF, 1'b0);
    run_one(14'b011010_1_0010000, 8'h00, 8'hFF, 1'b0);
    run_one(14'b011110_0_0010000, 8'h00, 8'h01, 1'b0);
    run_one(14'b011110_0_0010000, 8'h00, 8'h02, 1'b0);
    // R7 rotates through carry
    run_one(14'b010110_1_0001000, 8'h00, 8'h01, 1'b1);
    run_one(14'b010101_0_0001000, 8'h00, 8'h80, 1'b0);
    // R8 swap, R4 complement to zero
    run_one(14'b010111_1_0001000, 8'h00, 8'hA5, 1'b0);
    run_one(14'b011111_0_0001000, 8'h00, 8'hFF, 1'b0);
    // R9 bit tests on bit 7 and bit 0
    run_one(14'b0001_111_0001000, 8'h00, 8'h7F, 1'b0);
    run_one(14'b0011_111_0001000, 8'h00, 8'h80, 1'b0);
    run_one(14'b0000_000_0001000, 8'h00, 8'hFF, 1'b0);
    // R10, R11, R1
    run_one(14'b111010_00000000, 8'h77, 8'h00, 1'b0);
    run_one(14'b010000_10000000, 8'h77, 8'h12, 1'b0);
    run_one(14'b010001_00000001, 8'h77, 8'h12, 1'b0);
    run_one(14'b010001_10000001, 8'h77, 8'h12, 1'b0);
    // every encoding with random operands: R1..R12
    for (int k = 0; k < 16384; k++)
      run_one(14'(k), 8'($urandom), 8'($urandom), 1'($urandom));
    // biased toward decoded opcodes
    for (int k = 0; k < 6000; k++) begin
      logic [13:0] wd;
      wd = {opc_list[$urandom % N_OPC], 8'($urandom)};
      run_one(wd, 8'($urandom), 8'($urandom), 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule